// File: doc/BRIEF.md
# Debug Breakpoint Interrupt Request Logic

This block sits between an asynchronous, active-low breakpoint pin and a processor core's debug exception logic. A mode input selects between two uses of the pin. With the mode input low, the pin keeps its ordinary meaning: its synchronised level is presented as an active-high halt request, and no debug interrupt is ever raised. With the mode input high, the pin becomes edge-sensitive. A falling edge on the synchronised pin records a debug interrupt request.

A recorded request is held pending until the core signals an instruction boundary with its sample strobe. The core issues this strobe once per executed instruction. At that boundary the block emits a single-cycle exception-start pulse and drops the pending flag. The debug exception is then in service until the core acknowledges completion. Debug interrupts do not nest. Falling edges that arrive while an exception is in service are discarded, not queued.

Top module: `dbg_brk_req`

## Requirements
- R1: An active-low asynchronous reset immediately clears the pending flag and the start pulse and leaves the block not in service. A falling edge after release is accepted as a fresh request.
- R2: With edge_mode at 0, halt_req is 1 exactly when the synchronised pin is low. It follows a pin change on the second rising clock edge after it. req_pending stays 0 and exc_start never pulses.
- R3: With edge_mode at 1, halt_req stays 0.
- R4: With edge_mode at 1 and the block idle, a high-to-low change on brk_pin_n sets req_pending on the third rising clock edge after the change.
- R5: A low level held on the pin for any number of cycles produces exactly one request.
- R6: req_pending holds until a clock edge samples sample_stb high. At that edge req_pending falls, and exc_start is 1 for exactly the following cycle.
- R7: While in service, sample strobes produce no exc_start and falling edges are ignored, not queued. Service ends at the clock edge that samples exc_ack high.
- R8: Clearing edge_mode while a request is pending discards the request. Setting edge_mode again while the pin is held low creates no request.
- R9: A sample strobe with no request pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| brk_pin_n | input | 1 | Asynchronous breakpoint pin, active low |
| edge_mode | input | 1 | 1: the pin raises debug interrupts on falling edges; 0: the pin drives halt_req |
| sample_stb | input | 1 | Instruction-boundary sample point from the core |
| exc_ack | input | 1 | Debug exception finished |
| req_pending | output | 1 | A debug interrupt request is waiting for a sample point |
| exc_start | output | 1 | One-cycle pulse starting the debug exception |
| halt_req | output | 1 | Level halt request used in normal mode |

## Verification
Suppose the controller wrongly believes it is idle while an exception is in service. A falling edge during service then raises req_pending three edges later, and the next strobe produces an extra exc_start. The scoreboard rejects that pulse in the same cycle it appears. Now suppose the controller wrongly holds the in-service state after an acknowledge. The next genuine falling edge then never shows as pending, so the gap appears three clock edges after the edge. A wrong synchroniser depth shifts halt_req and req_pending by one cycle, and the bench samples each at its exact edge.

// File: rtl/dbg_brk_pkg.sv
package dbg_brk_pkg;

  typedef enum logic [1:0] {
    BRK_IDLE = 2'd0,
    BRK_PEND = 2'd1,
    BRK_SERV = 2'd2
  } brk_state_e;

endpackage

// File: rtl/dbg_brk_sync.sv
// Multi-stage level synchroniser for an asynchronous input.
module dbg_brk_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign stage_d[i] = async_in;
    end else begin : g_next
      assign stage_d[i] = stage_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= {STAGES{RST_VAL}};
    end else begin
      stage_q <= stage_d;
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/dbg_brk_edge.sv
// Falling-edge detector on an already synchronised level.
module dbg_brk_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic fall
);

  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
    end else begin
      prev_q <= prev_d;
    end
  end

  assign fall = prev_q & ~level;

endmodule

// File: rtl/dbg_brk_ctrl.sv
// Request controller: idle -> pending -> in service -> idle.
module dbg_brk_ctrl
  import dbg_brk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic edge_mode,
  input  logic fall,
  input  logic sample_stb,
  input  logic exc_ack,
  output logic pending,
  output logic in_service,
  output logic start
);

  brk_state_e state_q, state_d;
  logic       start_q, start_d;
  logic       state_en;

  always_comb begin
    state_d = state_q;
    start_d = 1'b0;
    unique case (state_q)
      BRK_IDLE: begin
        if (edge_mode && fall) state_d = BRK_PEND;
      end
      BRK_PEND: begin
        if (!edge_mode) begin
          state_d = BRK_IDLE;
        end else if (sample_stb) begin
          state_d = BRK_SERV;
          start_d = 1'b1;
        end
      end
      BRK_SERV: begin
        if (exc_ack) state_d = BRK_IDLE;
      end
      default: state_d = BRK_IDLE;
    endcase
  end

  assign state_en = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BRK_IDLE;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
    end else begin
      start_q <= start_d;
    end
  end

  assign pending    = (state_q == BRK_PEND);
  assign in_service = (state_q == BRK_SERV);
  assign start      = start_q;

endmodule

// File: rtl/dbg_brk_req.sv
// Top: breakpoint pin to debug interrupt request / halt request.
module dbg_brk_req #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic brk_pin_n,
  input  logic edge_mode,
  input  logic sample_stb,
  input  logic exc_ack,
  output logic req_pending,
  output logic exc_start,
  output logic halt_req
);

  logic pin_sync_n;
  logic pin_fall;
  logic in_svc;

  dbg_brk_sync #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(brk_pin_n),
    .sync_out(pin_sync_n)
  );

  dbg_brk_edge u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .level(pin_sync_n),
    .fall (pin_fall)
  );

  dbg_brk_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .edge_mode (edge_mode),
    .fall      (pin_fall),
    .sample_stb(sample_stb),
    .exc_ack   (exc_ack),
    .pending   (req_pending),
    .in_service(in_svc),
    .start     (exc_start)
  );

  assign halt_req = ~edge_mode & ~pin_sync_n;

endmodule

// File: rtl/dbg_brk_req_chk.sv
module dbg_brk_req_chk (
  input logic clk,
  input logic rst_n,
  input logic edge_mode,
  input logic sample_stb,
  input logic req_pending,
  input logic exc_start,
  input logic halt_req,
  input logic in_service
);

  // R6
  start_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_start |=> !exc_start);

  // R6
  start_from_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_start |-> $past(req_pending && sample_stb && edge_mode));

  // R6
  pending_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_pending && !sample_stb && edge_mode) |=> req_pending);

  // R3
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_mode |-> !halt_req);

  // R2
  normal_no_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_mode |=> !req_pending);

  // R7
  no_start_in_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_service && $past(in_service)) |-> !exc_start);

  // R7
  exclusive_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_pending, in_service}));

endmodule

bind dbg_brk_req dbg_brk_req_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .edge_mode  (edge_mode),
  .sample_stb (sample_stb),
  .req_pending(req_pending),
  .exc_start  (exc_start),
  .halt_req   (halt_req),
  .in_service (in_svc)
);

// File: tb/dbg_brk_req_bench.sv
`timescale 1ns/1ps
module dbg_brk_req_bench;

  logic clk = 1'b0;
  logic rst_n;
  logic brk_pin_n;
  logic edge_mode;
  logic sample_stb;
  logic exc_ack;
  logic req_pending;
  logic exc_start;
  logic halt_req;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 1'b0;
  int exp_q[$];

  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  dbg_brk_req u_dbg_brk_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .brk_pin_n  (brk_pin_n),
    .edge_mode  (edge_mode),
    .sample_stb (sample_stb),
    .exc_ack    (exc_ack),
    .req_pending(req_pending),
    .exc_start  (exc_start),
    .halt_req   (halt_req)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  // driver: strobe expected to start an exception, push the expected cycle
  task automatic strobe_expect_start();
    sample_stb = 1'b1;
    exp_q.push_back(cyc + 1);
    step(1);
    sample_stb = 1'b0;
  endtask

  task automatic strobe_no_start();
    sample_stb = 1'b1;
    step(1);
    sample_stb = 1'b0;
  endtask

  // monitor: every start pulse must match a queued expectation
  always @(negedge clk) begin
    if (rst_n === 1'b1 && exc_start === 1'b1) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R6/R7 unexpected start: actual cycle %0d expected none", cyc);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e != cyc) begin
          errors++;
          $display("FAIL R6 start cycle: actual %0d expected %0d", cyc, e);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; brk_pin_n = 1'b1; edge_mode = 1'b0;
    sample_stb = 1'b0; exc_ack = 1'b0;
    step(3);
    chk("R1", "pending at reset", req_pending, 1'b0);
    chk("R1", "start at reset", exc_start, 1'b0);
    chk("R1", "halt at reset", halt_req, 1'b0);
    rst_n = 1'b1;
    step(2);

    // normal mode
    brk_pin_n = 1'b0;
    step(1);
    chk("R2", "halt one edge after low", halt_req, 1'b0);
    step(1);
    chk("R2", "halt two edges after low", halt_req, 1'b1);
    step(1);
    chk("R2", "pending in normal mode", req_pending, 1'b0);
    strobe_no_start();
    step(5);
    chk("R2", "pending after strobe normal", req_pending, 1'b0);
    brk_pin_n = 1'b1;
    step(1);
    chk("R2", "halt one edge after release", halt_req, 1'b1);
    step(1);
    chk("R2", "halt two edges after release", halt_req, 1'b0);

    // edge mode request
    edge_mode = 1'b1;
    step(2);
    brk_pin_n = 1'b0;
    step(2);
    chk("R3", "halt in edge mode", halt_req, 1'b0);
    chk("R4", "pending before third edge", req_pending, 1'b0);
    step(1);
    chk("R4", "pending at third edge", req_pending, 1'b1);
    step(20);
    chk("R6", "pending held without strobe", req_pending, 1'b1);
    strobe_expect_start();
    chk("R6", "pending cleared at start", req_pending, 1'b0);
    chk("R6", "start pulse", exc_start, 1'b1);
    step(1);
    chk("R6", "start ends after one cycle", exc_start, 1'b0);

    // nested request while in service
    brk_pin_n = 1'b1;
    step(3);
    brk_pin_n = 1'b0;
    step(4);
    chk("R7", "edge ignored in service", req_pending, 1'b0);
    strobe_no_start();
    chk("R7", "no start in service", exc_start, 1'b0);
    exc_ack = 1'b1;
    step(1);
    exc_ack = 1'b0;
    step(5);
    chk("R7", "edge not queued after ack", req_pending, 1'b0);

    // new request after service, then held low level
    brk_pin_n = 1'b1;
    step(3);
    brk_pin_n = 1'b0;
    step(3);
    chk("R7", "new edge accepted after ack", req_pending, 1'b1);
    strobe_expect_start();
    exc_ack = 1'b1;
    step(1);
    exc_ack = 1'b0;
    step(10);
    chk("R5", "held low gives one request", req_pending, 1'b0);

    // strobe with nothing pending
    sample_stb = 1'b1;
    step(3);
    sample_stb = 1'b0;
    chk("R9", "pending after idle strobes", req_pending, 1'b0);
    chk("R9", "start after idle strobes", exc_start, 1'b0);

    // mode cleared while pending
    brk_pin_n = 1'b1;
    step(3);
    brk_pin_n = 1'b0;
    step(3);
    chk("R8", "pending before mode clear", req_pending, 1'b1);
    edge_mode = 1'b0;
    step(1);
    chk("R8", "pending discarded", req_pending, 1'b0);
    chk("R2", "halt follows low pin", halt_req, 1'b1);
    strobe_no_start();
    chk("R8", "no start after discard", exc_start, 1'b0);
    edge_mode = 1'b1;
    step(3);
    chk("R8", "no request from held level", req_pending, 1'b0);

    // asynchronous reset while pending
    brk_pin_n = 1'b1;
    step(3);
    brk_pin_n = 1'b0;
    step(3);
    chk("R1", "pending before reset", req_pending, 1'b1);
    rst_n = 1'b0;
    #1;
    chk("R1", "async clear of pending", req_pending, 1'b0);
    brk_pin_n = 1'b1;
    step(2);
    rst_n = 1'b1;
    step(2);
    brk_pin_n = 1'b0;
    step(3);
    chk("R1", "fresh request after reset", req_pending, 1'b1);
    strobe_expect_start();
    exc_ack = 1'b1;
    step(1);
    exc_ack = 1'b0;
    step(5);

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R6 missing starts: actual %0d outstanding expected 0", exp_q.size());
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule